// File: doc/BRIEF.md
# External Area Chip-Select Decoder

This block sits between an internal bus master and the external bus pins of a chip. Each access request carries a 24-bit address. The block matches that address against three fixed external windows: a large memory window, a coprocessor window and a small I/O window. It then drives one select strobe for the window that matched, together with only the low address bits that the window needs.

A mode bit, taken when the request is accepted, chooses between two ways of running the access:

- **Normal extended mode**: one access cycle, with separate address pins.
- **Multiplexed mode**: address and data share one bus of `BUS_W` pins (8 or 16). The access has an address phase, marked by an address-hold strobe, followed by a data phase.

A request whose address lies outside every window completes at once with an error flag and runs no external cycle. Two polarity bits set the active level of the strobes. One bit covers the three select strobes as a group, and the other covers the address-hold strobe. Both are sampled only while the block is idle.

The state machine has five states:

| State | Role |
|---|---|
| IDLE | Waits for a request |
| NRM | Single normal-mode access cycle |
| MADR | Multiplexed address phase |
| MDAT | Multiplexed data phase |
| MISS | Error completion |

Its transitions are:

- IDLE→NRM: a request hits a window and the mode bit is 0.
- IDLE→MADR: a request hits a window and the mode bit is 1.
- IDLE→MISS: a request hits no window.
- MADR→MDAT: always.
- NRM→IDLE, MDAT→IDLE and MISS→IDLE: always.
- IDLE→IDLE: no request.

Top module: `ext_sel_decoder`

## Requirements
- R1: The mode bit is taken at the clock edge that accepts a request. A value of 0 gives a normal access: one active cycle, with `done` in that same cycle, which is the first cycle after acceptance. A value of 1 gives a two-cycle multiplexed access, with `done` in the second cycle.
- R2: In normal mode, addresses 0xF80000 through 0xFBFFFF activate `sel_big`, and `ext_addr` carries address bits 17:0 with every higher bit zero.
- R3: In both modes, addresses 0xFFC000 through 0xFFDFFF activate `sel_cp`, with address bits 12:0 kept.
- R4: In both modes, addresses 0xFFF000 through 0xFFF7FF activate `sel_io`, with address bits 10:0 kept.
- R5: In multiplexed mode the big window shrinks to 0xF80000 through 0xF8FFFF, with bits 15:0 kept. Addresses 0xF90000 through 0xFBFFFF then hit no window.
- R6: An address outside every window produces, in the one cycle after acceptance, `done` and `err` together, with every select inactive and `ad_oe` low. At most one select is ever active.
- R7: In the multiplexed address phase, `ahold` is active, `ad_oe` is 1, `ad_out` carries the low `BUS_W` bits of the kept address, and the window select is active.
- R8: In the multiplexed data phase, `ahold` is inactive and the select stays active. A write drives `wdata` with `ad_oe` set to 1. A read leaves `ad_oe` at 0, and `rd_data` shows the value of `ad_in` from that cycle, starting in the next cycle.
- R9: During a normal access, `ext_addr` carries the kept address. During a multiplexed access, it carries the kept address with its low `BUS_W` bits zeroed. When no access is in its active cycles, `ext_addr` is 0.
- R10: `pol_sel` set to 1 makes all three selects active-high. Set to 0, it makes them active-low. An inactive select sits at the opposite level, and this includes idle cycles.
- R11: `pol_ah` sets the level of `ahold` in the same way, independently of `pol_sel`.
- R12: The polarity bits are sampled only in IDLE. The values present at the accepting edge govern the whole access, including the first idle cycle after it. Changes made during an access have no effect on it.
- R13: A normal write drives `wdata` on `ad_out` with `ad_oe` set to 1 during the access cycle. A normal read leaves `ad_oe` at 0 and captures `ad_in` into `rd_data`, visible from the next cycle.
- R14: `done` is a one-cycle pulse. Requests, addresses, mode and write data presented while an access is in progress are ignored, so no second access starts from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, taken in IDLE |
| addr | input | 24 | Access address |
| wr | input | 1 | 1 = write, 0 = read |
| mux_mode | input | 1 | 0 = normal extended, 1 = multiplexed |
| wdata | input | BUS_W | Write data |
| ad_in | input | BUS_W | Data read from the external bus |
| pol_sel | input | 1 | Select group polarity, 1 = active-high |
| pol_ah | input | 1 | Address-hold polarity, 1 = active-high |
| sel_big | output | 1 | Big window select strobe |
| sel_cp | output | 1 | Coprocessor window select strobe |
| sel_io | output | 1 | I/O window select strobe |
| ahold | output | 1 | Address-hold strobe |
| ext_addr | output | 24 | Truncated external address |
| ad_out | output | BUS_W | Data or shared address/data out |
| ad_oe | output | 1 | Output enable for `ad_out` |
| rd_data | output | BUS_W | Captured read data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | No window matched, valid with `done` |

## Verification
The bench builds the block with `BUS_W` = 8. In multiplexed mode, address bits 15:8 of the big window therefore appear on `ext_addr`, while bits 7:0 go out on the shared bus. This shows that the split between the two carriers follows the parameter rather than the window size. Random window addresses, exact window edges in both modes, and polarity and request changes made mid-access together reach every state and every transition.

// File: rtl/ext_sel_pkg.sv
`timescale 1ns/1ps
package ext_sel_pkg;
    localparam int ADDR_W  = 24;
    localparam int NUM_SEL = 3;

    // Select vector bit positions
    localparam int SEL_BIG = 0;
    localparam int SEL_CP  = 1;
    localparam int SEL_IO  = 2;

    // Window bases and kept address bits
    localparam logic [ADDR_W-1:0] BIG_BASE = 24'hF80000;
    localparam logic [ADDR_W-1:0] CP_BASE  = 24'hFFC000;
    localparam logic [ADDR_W-1:0] IO_BASE  = 24'hFFF000;
    localparam int BIG_BITS_NRM = 18;
    localparam int BIG_BITS_MUX = 16;
    localparam int CP_BITS      = 13;
    localparam int IO_BITS      = 11;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_BIG  = 2'd1,
        WIN_CP   = 2'd2,
        WIN_IO   = 2'd3
    } win_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_NRM  = 3'd1,
        ST_MADR = 3'd2,
        ST_MDAT = 3'd3,
        ST_MISS = 3'd4
    } st_e;
endpackage

// File: rtl/ext_sel_window.sv
`timescale 1ns/1ps
module ext_sel_window
    import ext_sel_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              mux_mode,
    output win_e              win,
    output logic [ADDR_W-1:0] trunc
);
    function automatic logic [ADDR_W-1:0] low_mask(input int bits);
        logic [ADDR_W-1:0] m;
        m = '0;
        for (int i = 0; i < ADDR_W; i++) begin
            if (i < bits) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic in_win(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] base,
                                    input int bits);
        return (a & ~low_mask(bits)) == (base & ~low_mask(bits));
    endfunction

    int big_bits;

    always_comb begin
        big_bits = mux_mode ? BIG_BITS_MUX : BIG_BITS_NRM;
        win      = WIN_NONE;
        trunc    = '0;
        if (in_win(addr, BIG_BASE, big_bits)) begin
            win   = WIN_BIG;
            trunc = addr & low_mask(big_bits);
        end else if (in_win(addr, CP_BASE, CP_BITS)) begin
            win   = WIN_CP;
            trunc = addr & low_mask(CP_BITS);
        end else if (in_win(addr, IO_BASE, IO_BITS)) begin
            win   = WIN_IO;
            trunc = addr & low_mask(IO_BITS);
        end
    end

    // R5: the big window shrinks to its first 64 KB in multiplexed mode
    always_comb begin
        if (mux_mode && win == WIN_BIG)
            a_r5_big_shrinks: assert (addr[23:16] == 8'hF8)
                else $error("big window hit outside 0xF8xxxx in multiplexed mode");
    end

    // R2: normal big-window address never exceeds 18 bits
    always_comb begin
        if (!mux_mode && win == WIN_BIG)
            a_r2_big_trunc: assert (trunc[ADDR_W-1:BIG_BITS_NRM] == '0)
                else $error("big window kept address wider than 18 bits");
    end
endmodule

// File: rtl/ext_sel_strobe.sv
`timescale 1ns/1ps
module ext_sel_strobe
    import ext_sel_pkg::*;
(
    input  logic [NUM_SEL-1:0] sel_on,
    input  logic               ah_on,
    input  logic               pol_sel,
    input  logic               pol_ah,
    output logic [NUM_SEL-1:0] sel_lvl,
    output logic               ah_lvl
);
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        assign sel_lvl[g] = pol_sel ? sel_on[g] : ~sel_on[g];
    end

    assign ah_lvl = pol_ah ? ah_on : ~ah_on;
endmodule

// File: rtl/ext_sel_decoder.sv
`timescale 1ns/1ps
module ext_sel_decoder
    import ext_sel_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [23:0]       addr,
    input  logic              wr,
    input  logic              mux_mode,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [BUS_W-1:0]  ad_in,
    input  logic              pol_sel,
    input  logic              pol_ah,
    output logic              sel_big,
    output logic              sel_cp,
    output logic              sel_io,
    output logic              ahold,
    output logic [23:0]       ext_addr,
    output logic [BUS_W-1:0]  ad_out,
    output logic              ad_oe,
    output logic [BUS_W-1:0]  rd_data,
    output logic              done,
    output logic              err
);
    localparam logic [ADDR_W-1:0] MUX_LOW =
        {{(ADDR_W-BUS_W){1'b0}}, {BUS_W{1'b1}}};

    initial begin
        a_bus_width_legal: assert (BUS_W == 8 || BUS_W == 16)
            else $error("BUS_W must be 8 or 16");
    end

    st_e               st, st_nx;
    win_e              win_d, win_q;
    logic [ADDR_W-1:0] trunc_d, a_q;
    logic              wr_q;
    logic [BUS_W-1:0]  wd_q, rd_q;
    logic              pol_sel_q, pol_ah_q;
    logic [NUM_SEL-1:0] sel_on, sel_lvl;
    logic              ah_on, ah_lvl;

    ext_sel_window u_win (
        .addr     (addr),
        .mux_mode (mux_mode),
        .win      (win_d),
        .trunc    (trunc_d)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (req) begin
                if (win_d == WIN_NONE) st_nx = ST_MISS;
                else if (mux_mode)     st_nx = ST_MADR;
                else                   st_nx = ST_NRM;
            end
            ST_NRM:  st_nx = ST_IDLE;
            ST_MADR: st_nx = ST_MDAT;
            ST_MDAT: st_nx = ST_IDLE;
            ST_MISS: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // Access capture, polarity sampling and read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q     <= WIN_NONE;
            a_q       <= '0;
            wr_q      <= 1'b0;
            wd_q      <= '0;
            rd_q      <= '0;
            pol_sel_q <= 1'b0;
            pol_ah_q  <= 1'b0;
        end else begin
            if (st == ST_IDLE) begin
                pol_sel_q <= pol_sel;
                pol_ah_q  <= pol_ah;
                if (req) begin
                    win_q <= win_d;
                    a_q   <= trunc_d;
                    wr_q  <= wr;
                    wd_q  <= wdata;
                end
            end
            if ((st == ST_NRM || st == ST_MDAT) && !wr_q)
                rd_q <= ad_in;
        end
    end

    // Outputs per state
    always_comb begin
        sel_on   = '0;
        ah_on    = 1'b0;
        ext_addr = '0;
        ad_out   = '0;
        ad_oe    = 1'b0;
        done     = 1'b0;
        err      = 1'b0;
        unique case (st)
            ST_IDLE: ;
            ST_NRM: begin
                sel_on[win_q == WIN_BIG ? SEL_BIG : win_q == WIN_CP ? SEL_CP : SEL_IO] = 1'b1;
                ext_addr = a_q;
                ad_out   = wr_q ? wd_q : '0;
                ad_oe    = wr_q;
                done     = 1'b1;
            end
            ST_MADR: begin
                sel_on[win_q == WIN_BIG ? SEL_BIG : win_q == WIN_CP ? SEL_CP : SEL_IO] = 1'b1;
                ah_on    = 1'b1;
                ext_addr = a_q & ~MUX_LOW;
                ad_out   = a_q[BUS_W-1:0];
                ad_oe    = 1'b1;
            end
            ST_MDAT: begin
                sel_on[win_q == WIN_BIG ? SEL_BIG : win_q == WIN_CP ? SEL_CP : SEL_IO] = 1'b1;
                ext_addr = a_q & ~MUX_LOW;
                ad_out   = wr_q ? wd_q : '0;
                ad_oe    = wr_q;
                done     = 1'b1;
            end
            ST_MISS: begin
                done = 1'b1;
                err  = 1'b1;
            end
            default: ;
        endcase
    end

    ext_sel_strobe u_strobe (
        .sel_on  (sel_on),
        .ah_on   (ah_on),
        .pol_sel (pol_sel_q),
        .pol_ah  (pol_ah_q),
        .sel_lvl (sel_lvl),
        .ah_lvl  (ah_lvl)
    );

    assign sel_big = sel_lvl[SEL_BIG];
    assign sel_cp  = sel_lvl[SEL_CP];
    assign sel_io  = sel_lvl[SEL_IO];
    assign ahold   = ah_lvl;
    assign rd_data = rd_q;

    // R6: a miss leaves every select strobe at its inactive level
    a_r6_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ({sel_io, sel_cp, sel_big} == (pol_sel_q ? 3'b000 : 3'b111)) && !ad_oe);

    // R6: selects are mutually exclusive
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_on));

    // R7: the address phase is followed by the data phase, which completes
    a_r7_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
        ah_on |=> (done && !ah_on && !err));

    // R12: strobe levels and address hold steady across the two phases
    a_r12_no_glitch: assert property (@(posedge clk) disable iff (!rst_n)
        ah_on |=> ($stable({sel_io, sel_cp, sel_big}) && $stable(ext_addr)));

    // R14: done lasts one cycle
    a_r14_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R13: the bus is never driven while idle
    a_r13_idle_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (!ad_oe && ext_addr == '0));
endmodule

// File: tb/ext_sel_decoder_test.sv
`timescale 1ns/1ps
module ext_sel_decoder_test;
    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [23:0]   addr = '0;
    logic          wr = 1'b0;
    logic          mux_mode = 1'b0;
    logic [BW-1:0] wdata = '0;
    logic [BW-1:0] ad_in = '0;
    logic          pol_sel = 1'b0;
    logic          pol_ah = 1'b0;
    logic          sel_big, sel_cp, sel_io, ahold, ad_oe, done, err;
    logic [23:0]   ext_addr;
    logic [BW-1:0] ad_out, rd_data;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    ext_sel_decoder #(.BUS_W(BW)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .wr(wr),
        .mux_mode(mux_mode), .wdata(wdata), .ad_in(ad_in),
        .pol_sel(pol_sel), .pol_ah(pol_ah),
        .sel_big(sel_big), .sel_cp(sel_cp), .sel_io(sel_io), .ahold(ahold),
        .ext_addr(ext_addr), .ad_out(ad_out), .ad_oe(ad_oe),
        .rd_data(rd_data), .done(done), .err(err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int ewin(input logic [23:0] a, input bit m);
        if (a >= 24'hF80000 && a <= (m ? 24'hF8FFFF : 24'hFBFFFF)) return 1;
        if (a >= 24'hFFC000 && a <= 24'hFFDFFF) return 2;
        if (a >= 24'hFFF000 && a <= 24'hFFF7FF) return 3;
        return 0;
    endfunction

    function automatic logic [23:0] etrunc(input logic [23:0] a, input bit m, input int w);
        case (w)
            1:       return m ? (a & 24'h00FFFF) : (a & 24'h03FFFF);
            2:       return a & 24'h001FFF;
            3:       return a & 24'h0007FF;
            default: return 24'h0;
        endcase
    endfunction

    // Select levels as {io, cp, big}
    function automatic logic [2:0] esel(input int w, input bit p);
        logic [2:0] on;
        on = (w == 1) ? 3'b001 : (w == 2) ? 3'b010 : (w == 3) ? 3'b100 : 3'b000;
        return p ? on : ~on;
    endfunction

    function automatic string wtag(input int w, input bit m);
        if (w == 1) return m ? "R5" : "R2";
        if (w == 2) return "R3";
        if (w == 3) return "R4";
        return "R6";
    endfunction

    task automatic access(input logic [23:0] a, input bit w_r, input bit m,
                          input logic [BW-1:0] wd, input logic [BW-1:0] rin,
                          input bit ps, input bit pa);
        int win;
        logic [23:0] tr;
        win = ewin(a, m);
        tr  = etrunc(a, m, win);
        @(negedge clk);
        req = 1'b1; addr = a; wr = w_r; mux_mode = m; wdata = wd; ad_in = rin;
        pol_sel = ps; pol_ah = pa;
        @(negedge clk);
        // first cycle after acceptance
        if (win == 0) begin
            chk("R6 done", {31'b0, done}, 1);
            chk("R6 err", {31'b0, err}, 1);
            chk("R6 sel", {29'b0, sel_io, sel_cp, sel_big}, {29'b0, esel(0, ps)});
            chk("R6 oe", {31'b0, ad_oe}, 0);
            chk("R9 ext_addr miss", {8'b0, ext_addr}, 0);
        end else if (!m) begin
            chk({wtag(win, m), " sel"}, {29'b0, sel_io, sel_cp, sel_big}, {29'b0, esel(win, ps)});
            chk("R1 normal done", {31'b0, done}, 1);
            chk("R6 no err", {31'b0, err}, 0);
            chk("R11 ahold idle level", {31'b0, ahold}, {31'b0, ~pa});
            chk("R9 ext_addr normal", {8'b0, ext_addr}, {8'b0, tr});
            chk("R13 oe", {31'b0, ad_oe}, {31'b0, w_r});
            if (w_r) chk("R13 wdata", {24'b0, ad_out}, {24'b0, wd});
        end else begin
            chk({wtag(win, m), " sel"}, {29'b0, sel_io, sel_cp, sel_big}, {29'b0, esel(win, ps)});
            chk("R7 ahold active", {31'b0, ahold}, {31'b0, pa});
            chk("R7 oe", {31'b0, ad_oe}, 1);
            chk("R7 addr on bus", {24'b0, ad_out}, {24'b0, tr[BW-1:0]});
            chk("R9 ext_addr mux", {8'b0, ext_addr}, {8'b0, tr & ~24'h0000FF});
            chk("R1 mux no done yet", {31'b0, done}, 0);
        end
        // disturb every input but ad_in while busy
        req = 1'b1; addr = $urandom; wr = ~w_r; mux_mode = ~m; wdata = ~wd;
        pol_sel = ~ps; pol_ah = ~pa;
        if (win != 0 && m) begin
            @(negedge clk);
            chk("R12 sel held", {29'b0, sel_io, sel_cp, sel_big}, {29'b0, esel(win, ps)});
            chk("R8 ahold released", {31'b0, ahold}, {31'b0, ~pa});
            chk("R1 mux done", {31'b0, done}, 1);
            chk("R9 ext_addr held", {8'b0, ext_addr}, {8'b0, tr & ~24'h0000FF});
            chk("R8 oe", {31'b0, ad_oe}, {31'b0, w_r});
            if (w_r) chk("R8 wdata", {24'b0, ad_out}, {24'b0, wd});
        end
        @(negedge clk);
        // first idle cycle
        chk("R14 done pulse", {31'b0, done}, 0);
        chk("R10 idle sel level", {29'b0, sel_io, sel_cp, sel_big}, {29'b0, esel(0, ps)});
        chk("R11 idle ahold", {31'b0, ahold}, {31'b0, ~pa});
        chk("R9 idle ext_addr", {8'b0, ext_addr}, 0);
        if (win != 0 && !w_r)
            chk(m ? "R8 rd_data" : "R13 rd_data", {24'b0, rd_data}, {24'b0, rin});
        req = 1'b0;
        @(negedge clk);
        chk("R14 no extra access", {31'b0, done}, 0);
    endtask

    function automatic logic [23:0] pick_addr();
        logic [23:0] a;
        case ($urandom % 8)
            0, 1: a = 24'hF80000 + ($urandom % 24'h40000);
            2:    a = 24'hFFC000 + ($urandom % 24'h2000);
            3:    a = 24'hFFF000 + ($urandom % 24'h800);
            4:    a = 24'hF80000 + ($urandom % 24'h10000);
            5:    a = 24'hFFE000 + ($urandom % 24'h2000);
            default: a = $urandom;
        endcase
        return a;
    endfunction

    initial begin
        logic [23:0] edges [14];
        void'($urandom(32'd1234));
        edges = '{24'hF7FFFF, 24'hF80000, 24'hF8FFFF, 24'hF90000, 24'hFBFFFF,
                  24'hFC0000, 24'hFFBFFF, 24'hFFC000, 24'hFFDFFF, 24'hFFE000,
                  24'hFFEFFF, 24'hFFF000, 24'hFFF7FF, 24'hFFF800};
        repeat (3) @(negedge clk);
        // reset state: polarity registers clear to active-low
        chk("R14 reset done", {31'b0, done}, 0);
        chk("R6 reset err", {31'b0, err}, 0);
        chk("R10 reset sel", {29'b0, sel_io, sel_cp, sel_big}, 32'h7);
        chk("R11 reset ahold", {31'b0, ahold}, 1);
        chk("R9 reset ext_addr", {8'b0, ext_addr}, 0);
        chk("R13 reset oe", {31'b0, ad_oe}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 14; i++) begin
            access(edges[i], 1'b0, 1'b0, 8'h5A, 8'hC3 ^ 8'(i), i[0], i[1]);
            access(edges[i], 1'b1, 1'b1, 8'hA5 ^ 8'(i), 8'h3C, i[1], i[0]);
        end
        for (int i = 0; i < 400; i++) begin
            access(pick_addr(), 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom),
                   1'($urandom), 1'($urandom));
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule